// File: doc/BRIEF.md
# I2C Slave Address and Reserved-Code Detector

This block listens to an I2C bus as a passive observer. It uses a system clock that runs much faster than the bus. SCL and SDA each pass through a synchroniser. Start and stop conditions are then found as level changes of SDA while SCL is high. After every start or repeated start, the block shifts in the first byte on SCL rising edges: seven address bits, most significant bit first, then the R/W bit.

On the falling SCL edge that ends the eighth clock, the block evaluates the byte:

- It compares the address against the local address input.
- It checks whether the byte falls into one of the reserved address groups, and if so which one.

Each outcome sets a flag that holds until the next start or stop. A hit raises a single-cycle interrupt together with a cause vector. A stop also raises the interrupt.

Software may pulse a release input. The block then forgets its flags and takes no notice of the bus, stop conditions included, until a fresh start. The address that follows that start is evaluated as usual.

Top module: `i2c_addr_watch`

## Requirements
- R1: When the seven received address bits equal `own_addr`, `match_o` goes to 1. `irq_o` pulses with `cause_o` bit 0 set.
- R2: The interrupt for an address byte appears on the third rising system-clock edge after SCL falls at the pin at the end of the eighth bus clock.
- R3: When the upper four address bits are 0000 or 1111, `ext_o` goes to 1. `irq_o` pulses with `cause_o` bit 1 set, whether or not the address matches.
- R4: `resv_class_o` encodes the reserved group, judged from the 7 address bits and R/W:
  - 0 = none
  - 1 = 0000000 with R/W 0
  - 2 = 0000000 with R/W 1
  - 3 = 0000001
  - 4 = 0000010
  - 5 = 11110xx
  - 6 = any other 0000xxx or 1111xxx address

  A nonzero class occurs exactly when `ext_o` is 1.
- R5: When `own_addr` holds a 11110xx value and the same seven bits are received, `match_o` and `ext_o` are both set. `cause_o` is then 3'b011.
- R6: A stop condition pulses `irq_o` with `cause_o` = 3'b100, and clears `match_o`, `ext_o` and `resv_class_o`. The exception is standby.
- R7: A one-cycle `release_i` clears the flags and enters standby. In standby, neither an address nor a stop raises `irq_o` or sets a flag, until the next start. The address after that start is evaluated normally.
- R8: A start or repeated start clears `match_o`, `ext_o` and `resv_class_o`.
- R9: `irq_o` lasts one system clock. `cause_o` is nonzero only while `irq_o` is 1. An address byte that is neither a match nor reserved raises no interrupt.
- R10: After an address byte, data bytes on the bus leave the flags unchanged until the next start or stop.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| own_addr | input | 7 | Local 7-bit slave address |
| release_i | input | 1 | One-cycle pulse: enter standby until next start |
| match_o | output | 1 | Local address matched |
| ext_o | output | 1 | Reserved extension code received |
| resv_class_o | output | 3 | Reserved group code (see R4) |
| irq_o | output | 1 | One-cycle interrupt pulse |
| cause_o | output | 3 | bit0 match, bit1 extension code, bit2 stop |

## Verification
Every pin change passes two synchroniser flops, and the edge detector compares against one more register. An address or stop result therefore appears on `irq_o`, `cause_o` and the flags at the third rising system-clock edge after the SCL fall or SDA rise at the pins.

The bench driver records the cycle count at the instant it lowers SCL for the eighth bit. It then queues the expected cause, flags and class with a due cycle three later. The monitor samples on falling clock edges and compares each interrupt against the head of the queue, including that exact cycle. Any interrupt that arrives with nothing queued is counted as a failure, which covers the quiet cases: non-matching addresses and standby. Flag levels are also checked directly after repeated starts and after data bytes.

// File: rtl/i2c_aw_pkg.sv
package i2c_aw_pkg;

    localparam int ADDR_W  = 7;
    localparam int BYTE_W  = ADDR_W + 1;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam int CAUSE_W = 3;

    localparam int CAUSE_MATCH = 0;
    localparam int CAUSE_EXT   = 1;
    localparam int CAUSE_STOP  = 2;

    typedef enum logic [1:0] {
        PH_LISTEN  = 2'd0,
        PH_SHIFT   = 2'd1,
        PH_HOLD    = 2'd2,
        PH_STANDBY = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        RC_NONE   = 3'd0,
        RC_GCALL  = 3'd1,
        RC_STARTB = 3'd2,
        RC_CBUS   = 3'd3,
        RC_ALTBUS = 3'd4,
        RC_TENBIT = 3'd5,
        RC_RSVD   = 3'd6
    } rclass_e;

    typedef struct packed {
        phase_e               phase;
        logic [CNT_W-1:0]     cnt;
        logic [BYTE_W-1:0]    shreg;
        logic                 match;
        logic                 ext;
        rclass_e              rclass;
        logic                 irq;
        logic [CAUSE_W-1:0]   cause;
    } watch_state_t;

endpackage

// File: rtl/i2c_aw_sync.sv
module i2c_aw_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stage_d[g] = d_i;
        end else begin : g_rest
            assign stage_d[g] = stage_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_aw_cond.sv
module i2c_aw_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign start_o    = prev_q.scl & scl_s & prev_q.sda & ~sda_s;
    assign stop_o     = prev_q.scl & scl_s & ~prev_q.sda & sda_s;
    assign scl_rise_o = ~prev_q.scl & scl_s;
    assign scl_fall_o = prev_q.scl & ~scl_s;

endmodule

// File: rtl/i2c_aw_decode.sv
module i2c_aw_decode
    import i2c_aw_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_i,
    output logic              match_o,
    output logic              ext_o,
    output rclass_e           class_o
);

    localparam int HI_W = 4;

    logic [ADDR_W-1:0] addr;
    logic              rw;
    logic [HI_W-1:0]   hi;

    assign addr = byte_i[BYTE_W-1:1];
    assign rw   = byte_i[0];
    assign hi   = addr[ADDR_W-1 -: HI_W];

    always_comb begin
        match_o = (addr == own_i);
        ext_o   = (hi == '0) || (hi == '1);
        class_o = RC_NONE;
        if (hi == '0) begin
            unique case (addr[ADDR_W-HI_W-1:0])
                3'b000:  class_o = rw ? RC_STARTB : RC_GCALL;
                3'b001:  class_o = RC_CBUS;
                3'b010:  class_o = RC_ALTBUS;
                default: class_o = RC_RSVD;
            endcase
        end else if (hi == '1) begin
            class_o = addr[ADDR_W-HI_W-1] ? RC_RSVD : RC_TENBIT;
        end
    end

endmodule

// File: rtl/i2c_addr_watch.sv
module i2c_addr_watch
    import i2c_aw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [6:0]        own_addr,
    input  logic              release_i,
    output logic              match_o,
    output logic              ext_o,
    output logic [2:0]        resv_class_o,
    output logic              irq_o,
    output logic [2:0]        cause_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic [1:0] line_s;
    logic       start_p, stop_p, scl_rise, scl_fall;
    logic       dec_match, dec_ext;
    rclass_e    dec_class;

    watch_state_t st_d, st_q;

    i2c_aw_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b11)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({scl_i, sda_i}),
        .q_o  (line_s)
    );

    i2c_aw_cond i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (line_s[1]),
        .sda_s     (line_s[0]),
        .start_o   (start_p),
        .stop_o    (stop_p),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall)
    );

    i2c_aw_decode i_dec (
        .byte_i (st_q.shreg),
        .own_i  (own_addr),
        .match_o(dec_match),
        .ext_o  (dec_ext),
        .class_o(dec_class)
    );

    always_comb begin
        st_d       = st_q;
        st_d.irq   = 1'b0;
        st_d.cause = '0;
        if (start_p) begin
            st_d.phase  = PH_SHIFT;
            st_d.cnt    = '0;
            st_d.match  = 1'b0;
            st_d.ext    = 1'b0;
            st_d.rclass = RC_NONE;
        end else if (release_i) begin
            st_d.phase  = PH_STANDBY;
            st_d.match  = 1'b0;
            st_d.ext    = 1'b0;
            st_d.rclass = RC_NONE;
        end else if (stop_p && st_q.phase != PH_STANDBY) begin
            st_d.phase             = PH_LISTEN;
            st_d.match             = 1'b0;
            st_d.ext               = 1'b0;
            st_d.rclass            = RC_NONE;
            st_d.irq               = 1'b1;
            st_d.cause[CAUSE_STOP] = 1'b1;
        end else if (st_q.phase == PH_SHIFT) begin
            if (scl_rise && st_q.cnt != LAST_BIT) begin
                st_d.shreg = {st_q.shreg[BYTE_W-2:0], line_s[0]};
                st_d.cnt   = st_q.cnt + 1'b1;
            end else if (scl_fall && st_q.cnt == LAST_BIT) begin
                st_d.phase              = PH_HOLD;
                st_d.match              = dec_match;
                st_d.ext                = dec_ext;
                st_d.rclass             = dec_class;
                st_d.irq                = dec_match | dec_ext;
                st_d.cause[CAUSE_MATCH] = dec_match;
                st_d.cause[CAUSE_EXT]   = dec_ext;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_LISTEN, cnt: '0, shreg: '0, match: 1'b0,
                      ext: 1'b0, rclass: RC_NONE, irq: 1'b0, cause: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign match_o      = st_q.match;
    assign ext_o        = st_q.ext;
    assign resv_class_o = st_q.rclass;
    assign irq_o        = st_q.irq;
    assign cause_o      = st_q.cause;

endmodule

// File: rtl/i2c_aw_checker.sv
module i2c_aw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       release_i,
    input logic       match_o,
    input logic       ext_o,
    input logic [2:0] resv_class_o,
    input logic       irq_o,
    input logic [2:0] cause_o
);

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_cause_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> cause_o == 3'b000);

    assert_cause_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> cause_o != 3'b000);

    assert_match_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_o) |-> irq_o && cause_o[0]);

    assert_ext_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_o) |-> irq_o && cause_o[1]);

    assert_class_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_class_o != 3'd0) == ext_o);

    assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && cause_o[2] |-> !match_o && !ext_o && resv_class_o == 3'd0);

    assert_release_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> !match_o && !ext_o);

endmodule

bind i2c_addr_watch i2c_aw_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .release_i   (release_i),
    .match_o     (match_o),
    .ext_o       (ext_o),
    .resv_class_o(resv_class_o),
    .irq_o       (irq_o),
    .cause_o     (cause_o)
);

// File: tb/test_i2c_addr_watch.sv
module test_i2c_addr_watch;

    localparam int HALF     = 8;
    localparam int LATENCY  = 3;
    localparam int WATCHDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic [6:0] own = 7'h3A;
    logic       rel = 1'b0;
    logic       match_o, ext_o, irq_o;
    logic [2:0] resv_class_o, cause_o;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic [2:0] cause;
        logic       m;
        logic       e;
        logic [2:0] cls;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    i2c_addr_watch i_i2c_addr_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda),
        .own_addr    (own),
        .release_i   (rel),
        .match_o     (match_o),
        .ext_o       (ext_o),
        .resv_class_o(resv_class_o),
        .irq_o       (irq_o),
        .cause_o     (cause_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda = 1'b1; half();
        scl = 1'b1; half();
        sda = 1'b0; half();
        scl = 1'b0; half();
    endtask

    task automatic bus_stop(input bit expect_irq, input string tag);
        exp_t it;
        sda = 1'b0; half();
        scl = 1'b1; half();
        sda = 1'b1;
        if (expect_irq) begin
            it = '{due: cyc + LATENCY, cause: 3'b100, m: 1'b0, e: 1'b0, cls: 3'd0, tag: tag};
            exp_q.push_back(it);
        end
        half();
    endtask

    // Sends one address byte plus a ninth (acknowledge) clock with SDA released.
    task automatic send_addr(input logic [7:0] b, input bit expect_irq, input logic [2:0] cause,
                             input logic m, input logic e, input logic [2:0] cls,
                             input string tag, input int rel_after);
        exp_t it;
        for (int i = 7; i >= 0; i--) begin
            if (rel_after == 7 - i) begin
                rel = 1'b1; @(negedge clk); rel = 1'b0;
            end
            sda = b[i]; half();
            scl = 1'b1; half();
            scl = 1'b0;
            if (i == 0 && expect_irq) begin
                it = '{due: cyc + LATENCY, cause: cause, m: m, e: e, cls: cls, tag: tag};
                exp_q.push_back(it);
            end
            half();
        end
        sda = 1'b1; half();
        scl = 1'b1; half();
        scl = 1'b0; half();
    endtask

    task automatic send_data(input logic [7:0] b);
        send_addr(b, 1'b0, 3'b000, 1'b0, 1'b0, 3'd0, "", -1);
    endtask

    // Monitor: every interrupt must match the head of the queue in cycle and content.
    always @(negedge clk) begin
        if (rst_n && irq_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected interrupt cause", int'(cause_o), 0);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                check(cyc == it.due, {it.tag, " R2 interrupt cycle"}, cyc, it.due);
                check(cause_o == it.cause, {it.tag, " cause"}, int'(cause_o), int'(it.cause));
                check(match_o == it.m, {it.tag, " match flag"}, int'(match_o), int'(it.m));
                check(ext_o == it.e, {it.tag, " ext flag"}, int'(ext_o), int'(it.e));
                check(resv_class_o == it.cls, {it.tag, " class"}, int'(resv_class_o), int'(it.cls));
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R11 reset state
        check({match_o, ext_o, resv_class_o, irq_o, cause_o} == 9'd0, "R11 reset outputs",
              int'({match_o, ext_o, resv_class_o, irq_o, cause_o}), 0);

        // R1 plain match, R10 flags held over data, R6 stop
        bus_start();
        send_addr({7'h3A, 1'b0}, 1'b1, 3'b001, 1'b1, 1'b0, 3'd0, "R1 match 3A", -1);
        send_data(8'h00);
        send_data(8'hFF);
        check(match_o == 1'b1, "R10 match held after data", int'(match_o), 1);
        bus_stop(1'b1, "R6 stop after match");
        half();
        check(match_o == 1'b0, "R6 match cleared by stop", int'(match_o), 0);

        // R9 non-matching ordinary address: no interrupt
        bus_start();
        send_addr({7'h55, 1'b1}, 1'b0, 3'b000, 1'b0, 1'b0, 3'd0, "", -1);
        check({match_o, ext_o} == 2'b00, "R9 no flags for 55", int'({match_o, ext_o}), 0);
        bus_stop(1'b1, "R6 stop after miss");

        // R3/R4 reserved groups with repeated starts (R8)
        bus_start();
        send_addr(8'h00, 1'b1, 3'b010, 1'b0, 1'b1, 3'd1, "R4 general call", -1);
        bus_start();
        check({ext_o, resv_class_o} == 4'd0, "R8 repeated start clears",
              int'({ext_o, resv_class_o}), 0);
        send_addr(8'h01, 1'b1, 3'b010, 1'b0, 1'b1, 3'd2, "R4 start byte", -1);
        bus_start();
        send_addr(8'h02, 1'b1, 3'b010, 1'b0, 1'b1, 3'd3, "R4 cbus", -1);
        bus_start();
        send_addr(8'h05, 1'b1, 3'b010, 1'b0, 1'b1, 3'd4, "R4 other bus", -1);
        bus_start();
        send_addr(8'h0A, 1'b1, 3'b010, 1'b0, 1'b1, 3'd6, "R4 reserved 0000101", -1);
        bus_start();
        send_addr(8'hF6, 1'b1, 3'b010, 1'b0, 1'b1, 3'd5, "R3 ten-bit prefix no match", -1);
        bus_start();
        send_addr(8'hFA, 1'b1, 3'b010, 1'b0, 1'b1, 3'd6, "R4 reserved 1111101", -1);
        bus_stop(1'b1, "R6 stop after reserved");

        // R5 local address is a ten-bit prefix
        own = 7'b1111010;
        bus_start();
        send_addr(8'hF4, 1'b1, 3'b011, 1'b1, 1'b1, 3'd5, "R5 prefix full match", -1);
        bus_start();
        send_addr(8'hF2, 1'b1, 3'b010, 1'b0, 1'b1, 3'd5, "R5 prefix upper only", -1);
        bus_stop(1'b1, "R6 stop after prefix");

        // R7 release mid-address: no interrupt, stop ignored, next start fresh
        own = 7'h3A;
        bus_start();
        send_addr({7'h3A, 1'b0}, 1'b0, 3'b000, 1'b0, 1'b0, 3'd0, "", 3);
        check({match_o, ext_o} == 2'b00, "R7 standby flags low", int'({match_o, ext_o}), 0);
        bus_stop(1'b0, "");
        half();
        check(irq_o == 1'b0, "R7 stop ignored in standby", int'(irq_o), 0);
        bus_start();
        send_addr({7'h3A, 1'b1}, 1'b1, 3'b001, 1'b1, 1'b0, 3'd0, "R7 fresh after start", -1);
        bus_stop(1'b1, "R6 final stop");

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R2 all expected interrupts seen", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule